// File: doc/BRIEF.md
# Configurable Slice Storage Elements

This block models the storage half of one programmable logic slice. It holds eight single-bit storage elements: four main ones (index 0 to 3, named A, B, C, D) and four secondary ones (index 4 to 7, named A5, B5, C5, D5). Each element has its own data input, clock enable and output. All eight share one slice clock, one set/reset control input and a global init pulse.

A static configuration word sets the behaviour. Three fields apply to the whole slice: the clock polarity, synchronous or asynchronous control, and latch mode. Latch mode applies only to the main elements. Each element also has its own init bit and reset-polarity bit, both stored inverted. A polarity request per element is checked against the single slice-wide clock polarity, and a mismatch is flagged as an illegal configuration.

The configuration word is captured only while the init pulse is high. The slice clock and the control inputs are level signals that a faster fabric clock `clk` samples. An edge of the slice clock is the change between two samples that follow each other. An asynchronous control takes effect at the next fabric edge, whatever the slice clock and the enables are doing.

Top module: `slice_store`

## Requirements
- R1: While `rst_n` is low, every `q_out` bit is forced to 1 at the next `clk` edge and `cfg_reject` is 0. The captured configuration returns to all zeros.
- R2: A `clk` edge with `init_pulse` high loads `q_out[i] = ~cfg_word[3+i]` and captures `cfg_word`. Changes to `cfg_word` while `init_pulse` is low have no effect.
- R3: Flip-flop mode with `cfg_word[0]=0`: element i takes `d_in[i]` when `slice_clk` goes from 0 to 1 and `ce_in[i]=1`. With `ce_in[i]=0`, or on a falling slice clock, it holds.
- R4: With `cfg_word[0]=1`, the flip-flops capture on a falling slice clock and ignore a rising one.
- R5: With `cfg_word[1]=1` (synchronous control), `sr_in=1` drives elements to their reset value only on an active slice-clock edge, even when `ce_in` is 0. Between edges it has no effect.
- R6: With `cfg_word[1]=0` (asynchronous control), `sr_in=1` drives every element to its reset value at the next `clk` edge, regardless of `slice_clk` and `ce_in`.
- R7: The reset value of element i is `~cfg_word[3+N_EL+i]`: a stored 1 clears the element and a stored 0 sets it.
- R8: With `cfg_word[2]=1`, main elements are latches. Each is transparent (follows `d_in` when `ce_in` is 1) while `slice_clk == cfg_word[0]`, and holds otherwise. Secondary elements stay edge-triggered flip-flops.
- R9: `cfg_reject` becomes 1 after an init capture in which any request bit `cfg_word[3+2*N_EL+i]` differs from `cfg_word[0]`. Otherwise it becomes 0.
- R10: `init_pulse` takes priority over `sr_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| init_pulse | input | 1 | Global init; loads initial values and opens configuration capture |
| cfg_word | input | 3+3*N_EL | bit0 clock invert, bit1 synchronous control, bit2 latch mode, then inverted init bits, inverted reset-polarity bits, and polarity request bits (N_EL each) |
| slice_clk | input | 1 | Shared slice clock (latch gate in latch mode) |
| sr_in | input | 1 | Shared set/reset control |
| d_in | input | N_EL | Per-element data |
| ce_in | input | N_EL | Per-element clock enable |
| q_out | output | N_EL | Per-element stored value |
| cfg_reject | output | 1 | Captured polarity requests conflict with the slice polarity |

## Verification
A wrong captured mode or a wrong sampled slice-clock bit shows at `q_out` on the next slice-clock transition. The element either captures on the wrong edge or fails to hold, so the fault is visible one fabric cycle after the transition. A wrong init or reset-polarity bit is visible one cycle after an init pulse or a control assertion. A wrong polarity decode is visible on `cfg_reject` one cycle after the init capture. The tests put each mode in place through an init pulse and then separate the edges: active edges, inactive edges, enable low, and control asserted between edges.

// File: rtl/slice_store_pkg.sv
`timescale 1ns/1ps
// Shared types for the slice storage model.
// Assumes: one slice-wide mode field group, decoded once per slice.
package slice_store_pkg;

    // Slice-wide mode bits, taken from the low bits of the configuration word.
    typedef struct packed {
        logic latch_en;   // main elements act as latches
        logic sync_ctl;   // control acts only on an active edge
        logic clk_inv;    // 1 = falling edge / inverted sense
    } slice_mode_t;

    localparam int MODE_W = 3;

endpackage

// File: rtl/slice_cfg_reg.sv
`timescale 1ns/1ps
// Configuration shadow: captures mode, reset polarity and the polarity
// conflict flag while the init pulse is high, and holds them otherwise.
// Assumes: configuration inputs are only meaningful during init.
module slice_cfg_reg
    import slice_store_pkg::*;
#(
    parameter int N_EL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_pulse,
    input  slice_mode_t      mode_in,
    input  logic [N_EL-1:0]  zrst_in,
    input  logic [N_EL-1:0]  pol_req_in,
    output slice_mode_t      mode_q,
    output logic [N_EL-1:0]  rst_val_q,
    output logic             reject_q
);

    logic conflict;

    // Any element asking for a polarity other than the slice one is illegal.
    always_comb begin
        conflict = |(pol_req_in ^ {N_EL{mode_in.clk_inv}});
    end

    // Capture configuration only during the init pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            rst_val_q <= '1;
            reject_q  <= 1'b0;
        end else if (init_pulse) begin
            mode_q    <= mode_in;
            rst_val_q <= ~zrst_in;
            reject_q  <= conflict;
        end
    end

endmodule

// File: rtl/slice_clk_sense.sv
`timescale 1ns/1ps
// Slice clock sensing: samples the slice clock with the fabric clock and
// produces an active-edge strobe for flip-flops and a gate level for latches.
// Assumes: the fabric clock is fast enough to see every slice clock level.
module slice_clk_sense (
    input  logic clk,
    input  logic slice_clk,
    input  logic clk_inv,
    output logic edge_act,
    output logic gate_act
);

    logic sclk_prev;

    // Previous sample of the slice clock (free-running, no reset needed).
    always_ff @(posedge clk) begin
        sclk_prev <= slice_clk;
    end

    // Edge per polarity; latch gate uses the opposite sense of the flip-flop clock.
    always_comb begin
        if (clk_inv) edge_act = sclk_prev & ~slice_clk;
        else         edge_act = ~sclk_prev & slice_clk;
        gate_act = (slice_clk == clk_inv);
    end

endmodule

// File: rtl/slice_elem.sv
`timescale 1ns/1ps
// One storage element. IS_MAIN selects whether latch mode is available.
// Priority: reset, init, asynchronous control, then edge/gate update where
// synchronous control beats the clock enable.
// Assumes: mode inputs are static outside init.
module slice_elem #(
    parameter bit IS_MAIN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_pulse,
    input  logic init_val,
    input  logic sync_ctl,
    input  logic latch_en,
    input  logic edge_act,
    input  logic gate_act,
    input  logic sr_in,
    input  logic rst_val,
    input  logic d,
    input  logic ce,
    output logic q
);

    logic as_latch;
    logic update;

    // Secondary elements never become latches.
    generate
        if (IS_MAIN) begin : g_main
            always_comb as_latch = latch_en;
        end else begin : g_sec
            always_comb as_latch = 1'b0 & latch_en;
        end
    endgenerate

    // Update window: gate level for a latch, active edge for a flip-flop.
    always_comb begin
        update = as_latch ? gate_act : edge_act;
    end

    // Storage with the documented priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b1;
        end else if (init_pulse) begin
            q <= init_val;
        end else if (!sync_ctl && sr_in) begin
            q <= rst_val;
        end else if (update) begin
            if (sync_ctl && sr_in) q <= rst_val;
            else if (ce)           q <= d;
        end
    end

endmodule

// File: rtl/slice_store.sv
`timescale 1ns/1ps
// Slice storage top: eight (2*N_MAIN) configurable storage elements sharing
// one slice clock, one control input and one init pulse.
// Configuration word layout: [0] clock invert, [1] synchronous control,
// [2] latch mode, then N_EL inverted init bits, N_EL inverted reset-polarity
// bits, N_EL polarity request bits.
// Assumes: all inputs are sampled by clk; cfg_word only matters during init.
module slice_store
    import slice_store_pkg::*;
#(
    parameter int N_MAIN = 4,
    localparam int N_EL  = 2 * N_MAIN,
    localparam int CFG_W = MODE_W + 3 * N_EL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_pulse,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              slice_clk,
    input  logic              sr_in,
    input  logic [N_EL-1:0]   d_in,
    input  logic [N_EL-1:0]   ce_in,
    output logic [N_EL-1:0]   q_out,
    output logic              cfg_reject
);

    localparam int ZI_LSB  = MODE_W;
    localparam int ZR_LSB  = MODE_W + N_EL;
    localparam int POL_LSB = MODE_W + 2 * N_EL;

    slice_mode_t      mode_in;
    slice_mode_t      mode_q;
    logic [N_EL-1:0]  rst_val_q;
    logic [N_EL-1:0]  init_vec;
    logic             edge_act;
    logic             gate_act;

    // Split the incoming configuration word into its fields.
    always_comb begin
        mode_in.clk_inv  = cfg_word[0];
        mode_in.sync_ctl = cfg_word[1];
        mode_in.latch_en = cfg_word[2];
        init_vec         = ~cfg_word[ZI_LSB +: N_EL];
    end

    slice_cfg_reg #(.N_EL(N_EL)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_pulse (init_pulse),
        .mode_in    (mode_in),
        .zrst_in    (cfg_word[ZR_LSB +: N_EL]),
        .pol_req_in (cfg_word[POL_LSB +: N_EL]),
        .mode_q     (mode_q),
        .rst_val_q  (rst_val_q),
        .reject_q   (cfg_reject)
    );

    slice_clk_sense u_sense (
        .clk       (clk),
        .slice_clk (slice_clk),
        .clk_inv   (mode_q.clk_inv),
        .edge_act  (edge_act),
        .gate_act  (gate_act)
    );

    // Main elements first, secondary elements after them.
    generate
        for (genvar g = 0; g < N_EL; g++) begin : g_elem
            slice_elem #(.IS_MAIN(g < N_MAIN)) u_elem (
                .clk        (clk),
                .rst_n      (rst_n),
                .init_pulse (init_pulse),
                .init_val   (init_vec[g]),
                .sync_ctl   (mode_q.sync_ctl),
                .latch_en   (mode_q.latch_en),
                .edge_act   (edge_act),
                .gate_act   (gate_act),
                .sr_in      (sr_in),
                .rst_val    (rst_val_q[g]),
                .d          (d_in[g]),
                .ce         (ce_in[g]),
                .q          (q_out[g])
            );
        end
    endgenerate

endmodule

// File: rtl/slice_store_chk.sv
`timescale 1ns/1ps
// Property checker for slice_store; keeps its own copy of the captured
// mode fields and checks port behaviour over time.
module slice_store_chk #(
    parameter int N_MAIN = 4,
    localparam int N_EL  = 2 * N_MAIN,
    localparam int CFG_W = 3 + 3 * N_EL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_pulse,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              slice_clk,
    input  logic              sr_in,
    input  logic [N_EL-1:0]   q_out,
    input  logic              cfg_reject
);

    localparam int ZI  = 3;
    localparam int ZR  = 3 + N_EL;
    localparam int POL = 3 + 2 * N_EL;

    logic            c_inv, c_sync, c_latch;
    logic [N_EL-1:0] c_zrst;
    logic            past_rst_q = 1'b0;

    // Independent copy of the configuration captured during init.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_inv <= 1'b0; c_sync <= 1'b0; c_latch <= 1'b0; c_zrst <= '0;
        end else if (init_pulse) begin
            c_inv   <= cfg_word[0];
            c_sync  <= cfg_word[1];
            c_latch <= cfg_word[2];
            c_zrst  <= cfg_word[ZR +: N_EL];
        end
    end

    // Reset state check one cycle after a reset edge.
    always_ff @(posedge clk) begin
        past_rst_q <= !rst_n;
        if (past_rst_q) begin
            AST_RESET_STATE: assert (q_out == '1 && !cfg_reject) // R1
                else $error("reset state wrong");
        end
    end

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (q_out == ~$past(cfg_word[ZI +: N_EL]))); // R2

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !init_pulse |=> $stable(cfg_reject)); // R2

    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_pulse && !sr_in && $stable(slice_clk)) |=> $stable(q_out[N_EL-1:N_MAIN])); // R3

    AST_ASYNC_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_pulse && sr_in && !c_sync) |=> (q_out == ~$past(c_zrst))); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_pulse && !sr_in && c_latch && (slice_clk != c_inv))
        |=> $stable(q_out[N_MAIN-1:0])); // R8

    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (cfg_reject ==
            |($past(cfg_word[POL +: N_EL]) ^ {N_EL{$past(cfg_word[0])}}))); // R9

endmodule

bind slice_store slice_store_chk #(.N_MAIN(N_MAIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_pulse (init_pulse),
    .cfg_word   (cfg_word),
    .slice_clk  (slice_clk),
    .sr_in      (sr_in),
    .q_out      (q_out),
    .cfg_reject (cfg_reject)
);

// File: tb/slice_store_tb.sv
`timescale 1ns/1ps
// Directed bench for slice_store: one task per scenario.
module slice_store_tb;

    localparam int N_MAIN = 4;
    localparam int N_EL   = 8;
    localparam int CFG_W  = 3 + 3 * N_EL;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              init_pulse;
    logic [CFG_W-1:0]  cfg_word;
    logic              slice_clk;
    logic              sr_in;
    logic [N_EL-1:0]   d_in;
    logic [N_EL-1:0]   ce_in;
    logic [N_EL-1:0]   q_out;
    logic              cfg_reject;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    slice_store #(.N_MAIN(N_MAIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse), .cfg_word(cfg_word),
        .slice_clk(slice_clk), .sr_in(sr_in), .d_in(d_in), .ce_in(ce_in),
        .q_out(q_out), .cfg_reject(cfg_reject)
    );

    function automatic logic [CFG_W-1:0] mk(input logic inv, input logic sync_c,
        input logic lat, input logic [7:0] zi, input logic [7:0] zr, input logic [7:0] pol);
        return {pol, zr, zi, lat, sync_c, inv};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive already set; advance one fabric cycle to the sampling point.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic load(input logic [CFG_W-1:0] w);
        cfg_word = w; init_pulse = 1'b1; step();
        init_pulse = 1'b0; ce_in = '0;
    endtask

    task automatic t_reset();
        chk("R1 q in reset", q_out, 8'hFF);
        chk("R1 reject in reset", {7'b0, cfg_reject}, 8'h00);
        rst_n = 1'b1; step();
        chk("R1 q after release", q_out, 8'hFF);
    endtask

    task automatic t_init();
        load(mk(0, 0, 0, 8'hA5, 8'h00, 8'h00));
        chk("R2 init load", q_out, 8'h5A);
        cfg_word = mk(1, 1, 1, 8'h00, 8'hFF, 8'hFF); step();
        chk("R2 cfg ignored q", q_out, 8'h5A);
        chk("R2 cfg ignored reject", {7'b0, cfg_reject}, 8'h00);
        slice_clk = 1'b1; d_in = 8'h11; ce_in = 8'hFF; step();
        chk("R2 old polarity kept", q_out, 8'h11);
        slice_clk = 1'b0; ce_in = '0; step();
    endtask

    task automatic t_ff_rise();
        load(mk(0, 0, 0, 8'hFF, 8'h00, 8'h00));
        chk("R2 init zeros", q_out, 8'h00);
        slice_clk = 1'b1; d_in = 8'hC3; ce_in = 8'hFF; step();
        chk("R3 rising capture", q_out, 8'hC3);
        slice_clk = 1'b0; d_in = 8'h3C; step();
        chk("R3 falling ignored", q_out, 8'hC3);
        slice_clk = 1'b1; d_in = 8'hFF; ce_in = 8'h0F; step();
        chk("R3 partial enable", q_out, 8'hCF);
        slice_clk = 1'b0; ce_in = '0; step();
    endtask

    task automatic t_ff_fall();
        load(mk(1, 0, 0, 8'h00, 8'h00, 8'hFF));
        chk("R4 init ones", q_out, 8'hFF);
        slice_clk = 1'b1; d_in = 8'h00; ce_in = 8'hFF; step();
        chk("R4 rising ignored", q_out, 8'hFF);
        slice_clk = 1'b0; step();
        chk("R4 falling capture", q_out, 8'h00);
        ce_in = '0; step();
    endtask

    task automatic t_sync();
        load(mk(0, 1, 0, 8'h0F, 8'hF0, 8'h00));
        chk("R5 init", q_out, 8'hF0);
        sr_in = 1'b1; step();
        chk("R5 ctrl between edges", q_out, 8'hF0);
        slice_clk = 1'b1; step();
        chk("R5 R7 ctrl on edge over ce", q_out, 8'h0F);
        sr_in = 1'b0; slice_clk = 1'b0; step();
    endtask

    task automatic t_async();
        load(mk(0, 0, 0, 8'hFF, 8'h3C, 8'h00));
        sr_in = 1'b1; step();
        chk("R6 R7 async ctrl", q_out, 8'hC3);
        sr_in = 1'b0; step();
        chk("R6 after release", q_out, 8'hC3);
    endtask

    task automatic t_prio();
        cfg_word = mk(0, 0, 0, 8'h00, 8'hFF, 8'h00);
        init_pulse = 1'b1; sr_in = 1'b1; step();
        chk("R10 init beats ctrl", q_out, 8'hFF);
        init_pulse = 1'b0; step();
        chk("R6 ctrl after init", q_out, 8'h00);
        sr_in = 1'b0; step();
    endtask

    task automatic t_latch();
        load(mk(0, 0, 1, 8'hFF, 8'h00, 8'h00));
        slice_clk = 1'b1; ce_in = 8'hFF; d_in = 8'hFF; step();
        chk("R8 gate closed, secondary edge", q_out, 8'hF0);
        slice_clk = 1'b0; d_in = 8'h5A; step();
        chk("R8 transparent", q_out, 8'hFA);
        d_in = 8'hA5; step();
        chk("R8 follows data", q_out, 8'hF5);
        slice_clk = 1'b1; d_in = 8'h00; step();
        chk("R8 closes and holds", q_out, 8'h05);
        d_in = 8'hFF; step();
        chk("R8 hold while closed", q_out, 8'h05);
        ce_in = '0; slice_clk = 1'b0; step();
    endtask

    task automatic t_reject();
        load(mk(0, 0, 0, 8'h00, 8'h00, 8'hFF));
        chk("R9 all mismatch", {7'b0, cfg_reject}, 8'h01);
        cfg_word = mk(0, 0, 0, 8'h00, 8'h00, 8'h00); step();
        chk("R9 R2 no capture", {7'b0, cfg_reject}, 8'h01);
        load(mk(1, 0, 0, 8'h00, 8'h00, 8'hFF));
        chk("R9 all match inverted", {7'b0, cfg_reject}, 8'h00);
        load(mk(0, 0, 0, 8'h00, 8'h00, 8'h01));
        chk("R9 single mismatch", {7'b0, cfg_reject}, 8'h01);
        load(mk(0, 0, 0, 8'h00, 8'h00, 8'h00));
        chk("R9 all match", {7'b0, cfg_reject}, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; init_pulse = 1'b0; cfg_word = '0; slice_clk = 1'b0;
        sr_in = 1'b0; d_in = '0; ce_in = '0;
        repeat (3) step();
        t_reset();
        t_init();
        t_ff_rise();
        t_ff_fall();
        t_sync();
        t_async();
        t_prio();
        t_latch();
        t_reject();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #80000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule